// File: doc/BRIEF.md
# Multi-Link Event Frame Synchronizer

This block collects one event from four parallel front-end links that share a clock. Each link delivers a frame on the cycles where its word-valid is high. A frame is four header words followed by 32 channel samples, so the four links of one front-end chip carry 128 channels between them. The links may start their frames a few cycles apart. The block stores each link's samples until every link has finished its frame. It then compares the front-end event tags that the links report and sends the event out as one stream.

Each merged event leaves as one status header word, followed by the samples of link 0, link 1, link 2 and link 3 in that order, 32 words per link. The header carries the following fields:
- a running event number;
- a bunch number, captured from an external input when the event begins;
- the tag reported by link 0;
- a saturating count of tag mismatches;
- a tag-mismatch flag;
- a link-skew flag.

Top module: `evsync_top`

## Requirements
- R1: After reset `out_valid` is 0. The first event header carries event number 0 and a mismatch count of 0.
- R2: A link frame starts on a cycle where that link's `link_sof` and `link_vld` are both high. That word is header word 0, and its low 8 bits are the link's event tag. Three more header words and then 32 sample words follow, one on each cycle where `link_vld` is high.
- R3: After all links have finished their frames, the block asserts `out_valid` for 129 consecutive cycles. `out_hdr` is 1 in the first of these cycles only. Then come the samples of link 0 channels 0..31, then link 1, then link 2, then link 3.
- R4: A sample word appears in `out_data[11:0]`, and the upper bits of `out_data` are zero.
- R5: The header layout is `out_data[45:30]` event number, `[29:18]` bunch, `[17:10]` link 0 tag, `[9:2]` mismatch count, `[1]` tag-mismatch flag, `[0]` skew flag. The tag-mismatch flag is 1 exactly when some link's tag differs from the tag of link 0.
- R6: The mismatch count rises by one for each event with a tag mismatch and stops at 255. The header shows the value that includes the current event.
- R7: A pulse on `cnt_clr` sets the mismatch count to 0 on the next cycle.
- R8: The event number rises by one after each event has been sent.
- R9: The bunch field holds the value of `bunch_in` in the cycle where the first frame start of the event was accepted.
- R10: The skew flag is set when a link's frame starts more than 2 cycles after the earliest link of the same event. A lag of exactly 2 cycles leaves the flag clear.
- R11: A `link_sof` that arrives while that link's frame is in progress, or while its completed frame is waiting to be sent, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by all links |
| rst | input | 1 | Synchronous active-high reset |
| link_sof | input | 4 | Frame start, one bit per link |
| link_vld | input | 4 | Word valid, one bit per link |
| link_word | input | 48 | Link words, link i in bits [12i+11:12i] |
| bunch_in | input | 12 | Bunch number to capture at event start |
| cnt_clr | input | 1 | Clears the mismatch count |
| out_valid | output | 1 | Output word valid |
| out_hdr | output | 1 | Output word is the status header |
| out_data | output | 46 | Header or zero-extended sample |

## Verification
Most events are sent with identical tags and aligned starts. These events establish the sample ordering and the event and bunch stamping. Start lags of exactly two and of three cycles separate the skew threshold from an off-by-one error. An event where only the last link's tag differs shows that every link is compared, not just one neighbour. A stray frame start in the middle of a frame shows that a busy link cannot be restarted. A clear pulse followed by a long run of mismatching events exercises the reset of the count and its saturation at 255.

// File: rtl/evsync_pkg.sv
`timescale 1ns/1ps
package evsync_pkg;
    localparam int NLINK    = 4;
    localparam int NCH      = 32;
    localparam int NHDRW    = 4;
    localparam int SMP_W    = 12;
    localparam int TAG_W    = 8;
    localparam int EVN_W    = 16;
    localparam int BX_W     = 12;
    localparam int ERRC_W   = 8;
    localparam int SKEW_LIM = 2;

    typedef struct packed {
        logic [EVN_W-1:0]  evt_num;
        logic [BX_W-1:0]   bunch;
        logic [TAG_W-1:0]  tag;
        logic [ERRC_W-1:0] err_cnt;
        logic              tag_err;
        logic              skew_err;
    } evhdr_t;

    localparam int OUT_W = $bits(evhdr_t);

    typedef enum logic [1:0] {
        ST_COLLECT = 2'd0,
        ST_HEAD    = 2'd1,
        ST_BODY    = 2'd2
    } evst_t;

    function automatic logic [ERRC_W-1:0] sat_inc(input logic [ERRC_W-1:0] v);
        return (&v) ? v : v + ERRC_W'(1);
    endfunction
endpackage

// File: rtl/evsync_link_rx.sv
`timescale 1ns/1ps
module evsync_link_rx #(
    parameter int DW    = 12,
    parameter int TW    = 8,
    parameter int HDRW  = 4,
    parameter int CH    = 32,
    localparam int FW   = HDRW + CH,
    localparam int CW   = $clog2(FW + 1),
    localparam int AW   = $clog2(CH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sof,
    input  logic          vld,
    input  logic [DW-1:0] word,
    input  logic          release_i,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    output logic [TW-1:0] tag,
    output logic          started,
    output logic          done,
    output logic          sof_acc
);
    logic          busy;
    logic [CW-1:0] wcnt;
    logic [CW-1:0] woff;
    logic [DW-1:0] mem [CH];

    assign sof_acc = sof & vld & ~busy & ~done;
    assign started = busy | done;
    assign woff    = wcnt - CW'(HDRW);
    assign rd_data = mem[rd_addr];

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            done <= 1'b0;
            wcnt <= '0;
            tag  <= '0;
        end else if (release_i) begin
            done <= 1'b0;
        end else if (sof_acc) begin
            busy <= 1'b1;
            wcnt <= CW'(1);
            tag  <= word[TW-1:0];
        end else if (busy && vld) begin
            wcnt <= wcnt + CW'(1);
            if (wcnt == CW'(FW - 1)) begin
                busy <= 1'b0;
                done <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (busy && vld && (wcnt >= CW'(HDRW)))
            mem[woff[AW-1:0]] <= word;
    end

    AST_TAG_HELD: assert property (@(posedge clk) disable iff (rst)
        (done && !release_i) |=> $stable(tag)); // R2

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst)
        (busy && vld && sof && wcnt != CW'(FW - 1)) |=> (busy && wcnt == $past(wcnt) + CW'(1))); // R11
endmodule

// File: rtl/evsync_skew_mon.sv
`timescale 1ns/1ps
module evsync_skew_mon #(
    parameter int LINKS = 4,
    parameter int LIM   = 2,
    localparam int SW   = $clog2(LIM + 2)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clear,
    input  logic [LINKS-1:0] sof_acc,
    output logic             skew_err
);
    logic          active;
    logic [SW-1:0] lag;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            active   <= 1'b0;
            lag      <= '0;
            skew_err <= 1'b0;
        end else if (!active) begin
            if (|sof_acc) begin
                active <= 1'b1;
                lag    <= SW'(1);
            end
        end else begin
            if (lag <= SW'(LIM))
                lag <= lag + SW'(1);
            if ((|sof_acc) && (lag > SW'(LIM)))
                skew_err <= 1'b1;
        end
    end

    AST_SKEW_STICKY: assert property (@(posedge clk) disable iff (rst)
        (skew_err && !clear) |=> skew_err); // R10

    AST_SKEW_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (!skew_err && active && lag <= SW'(LIM) && !clear) |=> !skew_err); // R10
endmodule

// File: rtl/evsync_top.sv
`timescale 1ns/1ps
module evsync_top
    import evsync_pkg::*;
#(
    parameter int LINKS    = NLINK,
    parameter int CH       = NCH,
    parameter int HDRW     = NHDRW,
    parameter int DW       = SMP_W,
    parameter int MAX_SKEW = SKEW_LIM,
    localparam int IDX_W   = $clog2(LINKS * CH),
    localparam int CH_AW   = $clog2(CH)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [LINKS-1:0]      link_sof,
    input  logic [LINKS-1:0]      link_vld,
    input  logic [LINKS*DW-1:0]   link_word,
    input  logic [BX_W-1:0]       bunch_in,
    input  logic                  cnt_clr,
    output logic                  out_valid,
    output logic                  out_hdr,
    output logic [OUT_W-1:0]      out_data
);
    logic [TAG_W-1:0]  tag_a [LINKS];
    logic [DW-1:0]     rd_a  [LINKS];
    logic [LINKS-1:0]  started, done, sof_acc;
    logic              skew_err, tag_mis, release_ev, all_done;

    evst_t             st;
    logic [IDX_W-1:0]  idx;
    logic [EVN_W-1:0]  evt_num_q;
    logic [BX_W-1:0]   bunch_q;
    logic [TAG_W-1:0]  tag0_q;
    logic [ERRC_W-1:0] err_cnt_q;
    logic              tag_err_q, skew_q;
    evhdr_t            hdr;

    for (genvar g = 0; g < LINKS; g++) begin : g_link
        evsync_link_rx #(.DW(DW), .TW(TAG_W), .HDRW(HDRW), .CH(CH)) i_rx (
            .clk       (clk),
            .rst       (rst),
            .sof       (link_sof[g]),
            .vld       (link_vld[g]),
            .word      (link_word[g*DW +: DW]),
            .release_i (release_ev),
            .rd_addr   (idx[CH_AW-1:0]),
            .rd_data   (rd_a[g]),
            .tag       (tag_a[g]),
            .started   (started[g]),
            .done      (done[g]),
            .sof_acc   (sof_acc[g])
        );
    end

    evsync_skew_mon #(.LINKS(LINKS), .LIM(MAX_SKEW)) i_skew (
        .clk      (clk),
        .rst      (rst),
        .clear    (release_ev),
        .sof_acc  (sof_acc),
        .skew_err (skew_err)
    );

    always_comb begin
        tag_mis = 1'b0;
        for (int i = 1; i < LINKS; i++)
            if (tag_a[i] != tag_a[0]) tag_mis = 1'b1;
    end

    assign all_done   = &done;
    assign release_ev = (st == ST_BODY) && (idx == IDX_W'(LINKS * CH - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_COLLECT;
            idx       <= '0;
            evt_num_q <= '0;
            bunch_q   <= '0;
            tag0_q    <= '0;
            tag_err_q <= 1'b0;
            skew_q    <= 1'b0;
        end else begin
            if ((st == ST_COLLECT) && !(|started) && (|sof_acc))
                bunch_q <= bunch_in;
            case (st)
                ST_COLLECT: if (all_done) begin
                    tag_err_q <= tag_mis;
                    skew_q    <= skew_err;
                    tag0_q    <= tag_a[0];
                    st        <= ST_HEAD;
                end
                ST_HEAD: begin
                    idx <= '0;
                    st  <= ST_BODY;
                end
                ST_BODY: begin
                    idx <= idx + IDX_W'(1);
                    if (release_ev) begin
                        st        <= ST_COLLECT;
                        evt_num_q <= evt_num_q + EVN_W'(1);
                    end
                end
                default: st <= ST_COLLECT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cnt_clr)
            err_cnt_q <= '0;
        else if ((st == ST_COLLECT) && all_done && tag_mis)
            err_cnt_q <= sat_inc(err_cnt_q);
    end

    always_comb begin
        hdr.evt_num  = evt_num_q;
        hdr.bunch    = bunch_q;
        hdr.tag      = tag0_q;
        hdr.err_cnt  = err_cnt_q;
        hdr.tag_err  = tag_err_q;
        hdr.skew_err = skew_q;
    end

    assign out_valid = (st == ST_HEAD) || (st == ST_BODY);
    assign out_hdr   = (st == ST_HEAD);
    assign out_data  = (st == ST_HEAD) ? hdr
                                       : {{(OUT_W - DW){1'b0}}, rd_a[idx[IDX_W-1:CH_AW]]};

    AST_ERRCNT_SAT: assert property (@(posedge clk) disable iff (rst)
        (err_cnt_q == '1 && !cnt_clr) |=> err_cnt_q == '1); // R6

    AST_ERRCNT_CLR: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> err_cnt_q == '0); // R7

    AST_EVN_STEP: assert property (@(posedge clk) disable iff (rst)
        !$stable(evt_num_q) |-> evt_num_q == $past(evt_num_q) + EVN_W'(1)); // R8

    AST_HDR_THEN_DATA: assert property (@(posedge clk) disable iff (rst)
        out_hdr |=> (out_valid && !out_hdr)); // R3
endmodule

// File: tb/test_evsync_top.sv
`timescale 1ns/1ps
module test_evsync_top;
    import evsync_pkg::*;

    typedef struct {
        logic             hdr;
        logic [OUT_W-1:0] val;
        string            req;
    } exp_t;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic [NLINK-1:0]        link_sof = '0;
    logic [NLINK-1:0]        link_vld = '0;
    logic [NLINK*SMP_W-1:0]  link_word = '0;
    logic [BX_W-1:0]         bunch_in = '0;
    logic                    cnt_clr = 1'b0;
    logic                    out_valid, out_hdr;
    logic [OUT_W-1:0]        out_data;

    exp_t        q[$];
    int          checks = 0;
    int          errors = 0;
    int          evn_m = 0;
    int          errc_m = 0;
    logic        prev_v = 1'b0;

    always #2 clk = ~clk;

    evsync_top i_evsync_top (
        .clk(clk), .rst(rst), .link_sof(link_sof), .link_vld(link_vld),
        .link_word(link_word), .bunch_in(bunch_in), .cnt_clr(cnt_clr),
        .out_valid(out_valid), .out_hdr(out_hdr), .out_data(out_data)
    );

    function automatic logic [SMP_W-1:0] smp(input int ev, input int l, input int c);
        return SMP_W'(ev * 7 + l * 40 + c * 3 + 5);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [OUT_W-1:0] act,
                       input logic [OUT_W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // monitor: pops expected words as the design emits them
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R3 unexpected output word", out_data, '0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk((out_hdr == e.hdr) && (out_data == e.val) && (e.hdr || prev_v),
                        e.req, out_data, e.val);
                end
            end
            prev_v = out_valid;
        end
    end

    task automatic run_event(input logic [4*TAG_W-1:0] tags, input logic [15:0] offs,
                             input logic [BX_W-1:0] bx, input bit ghost, input string lbl);
        int     mn, mx;
        bit     mis;
        evhdr_t h;
        mn = 15; mx = 0; mis = 0;
        for (int l = 0; l < NLINK; l++) begin
            int o;
            o = int'(offs[l*4 +: 4]);
            if (o < mn) mn = o;
            if (o > mx) mx = o;
            if (tags[l*TAG_W +: TAG_W] != tags[0 +: TAG_W]) mis = 1;
        end
        if (mis && errc_m < 255) errc_m++;
        h.evt_num  = EVN_W'(evn_m);
        h.bunch    = bx;
        h.tag      = tags[0 +: TAG_W];
        h.err_cnt  = ERRC_W'(errc_m);
        h.tag_err  = mis;
        h.skew_err = (mx - mn) > 2;
        q.push_back('{1'b1, OUT_W'(h), {lbl, " R5 R6 R8 R9 R10 header"}});
        for (int l = 0; l < NLINK; l++)
            for (int c = 0; c < NCH; c++)
                q.push_back('{1'b0, OUT_W'(smp(evn_m, l, c)), {lbl, " R2 R3 R4 sample"}});
        for (int t = 0; t <= mx + NHDRW + NCH - 1; t++) begin
            @(negedge clk);
            bunch_in = (t == mn) ? bx : ~bx;
            for (int l = 0; l < NLINK; l++) begin
                int w;
                w = t - int'(offs[l*4 +: 4]);
                if (w >= 0 && w < NHDRW + NCH) begin
                    link_vld[l] = 1'b1;
                    link_sof[l] = (w == 0) || (ghost && l == 2 && w == 10);
                    if (w == 0)
                        link_word[l*SMP_W +: SMP_W] = {4'hA, tags[l*TAG_W +: TAG_W]};
                    else if (w < NHDRW)
                        link_word[l*SMP_W +: SMP_W] = SMP_W'(12'h5A0 + w);
                    else
                        link_word[l*SMP_W +: SMP_W] = smp(evn_m, l, w - NHDRW);
                end else begin
                    link_vld[l] = 1'b0;
                    link_sof[l] = 1'b0;
                end
            end
        end
        @(negedge clk);
        link_vld = '0;
        link_sof = '0;
        evn_m++;
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 out_valid idle after reset", OUT_W'(out_valid), '0);
        // R1: first header carries event 0, count 0
        run_event({8'h11, 8'h11, 8'h11, 8'h11}, 16'h0000, 12'h123, 0, "R1 aligned");
        run_event({8'h12, 8'h12, 8'h12, 8'h12}, 16'h0120, 12'h456, 0, "R10 lag two");
        run_event({8'h13, 8'h13, 8'h13, 8'h13}, 16'h0300, 12'h789, 0, "R10 lag three");
        run_event({8'h99, 8'h14, 8'h14, 8'h14}, 16'h0000, 12'hABC, 0, "R5 last link differs");
        run_event({8'h15, 8'h15, 8'h15, 8'h15}, 16'h1000, 12'h0F0, 1, "R11 stray sof");
        @(negedge clk); cnt_clr = 1'b1;
        @(negedge clk); cnt_clr = 1'b0;
        errc_m = 0;
        run_event({8'h16, 8'h26, 8'h16, 8'h16}, 16'h0000, 12'h321, 0, "R7 after clear");
        for (int k = 0; k < 256; k++)
            run_event({8'h40, 8'h40, 8'h41, 8'h40}, 16'h0000, BX_W'(k), 0, "R6 saturate");
        run_event({8'h77, 8'h77, 8'h77, 8'h77}, 16'h0001, 12'hFEE, 0, "R6 R8 hold");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule